// File: doc/BRIEF.md
# Packed-SIMD Integer ALU

This block is a single-cycle vector ALU for a 32-bit datapath. It can treat each operand word as four 8-bit lanes or as two 16-bit lanes. Per lane it adds, subtracts, takes the minimum or maximum, and compares. It can also permute the lanes of A, merge the low halves of A and B, and form a dot product of the lanes, with or without an accumulator word C. A signedness select chooses how lanes are read for ordering, comparison and the dot product.

A scalar-replicate flag copies the lowest lane of B into every lane before the operation runs. This lets one scalar act against a whole vector. All inputs are sampled on a rising clock edge and the result appears on the output after that edge, so an operation issued in one cycle is visible in the next.

Top module: `simd_alu`

## Requirements
- R1: While rst_ni is low, result_o is zero. Otherwise result_o shows the result of the inputs sampled at the previous rising edge of clk_i.
- R2: With op_i = 0 (add) or 1 (subtract), each lane of the result is the lane of A plus or minus the matching lane of B, modulo 2^lane width. No carry or borrow crosses a lane boundary. lane8_i = 1 selects four 8-bit lanes and lane8_i = 0 selects two 16-bit lanes. Lane k occupies bits [k*w+w-1 : k*w].
- R3: With op_i = 2 (min) or 3 (max), each result lane is the smaller or larger of the two lanes. The lanes are read as two's complement when signed_i = 1 and as unsigned when signed_i = 0.
- R4: With op_i = 4 (equal) or 5 (A less than B, signedness per signed_i), each result lane is all ones where the condition holds and all zeros where it does not.
- R5: When scalar_i = 1, lane 0 of B replaces every lane of B for every operation except pack.
- R6: With op_i = 6 (shuffle), result lane k equals the lane of A whose index is held in the low bits of lane k of B. Two bits are used in 8-bit mode and one bit in 16-bit mode. The higher bits of that B lane are ignored.
- R7: With op_i = 7 (pack), the result is A[15:0] in bits [31:16] and the raw B[15:0] in bits [15:0], whatever the values of lane8_i and scalar_i.
- R8: With op_i = 8 (dot), the result is the sum of the lane-by-lane products of A and B. Each lane is sign- or zero-extended per signed_i, and the sum wraps modulo 2^32.
- R9: With op_i = 9 (dot accumulate), the result is C plus the R8 sum, modulo 2^32. Every other operation ignores C.
- R10: Values 10 to 15 of op_i produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| op_c_i | input | 32 | Accumulator for dot accumulate |
| op_i | input | 4 | Operation code (see R2 to R10) |
| lane8_i | input | 1 | 1: four 8-bit lanes, 0: two 16-bit lanes |
| signed_i | input | 1 | 1: lanes are two's complement |
| scalar_i | input | 1 | 1: replicate lane 0 of B into all lanes |
| result_o | output | 32 | Registered result |

## Verification
Scalar replication acts in the same cycle as every other lane function. It changes the index lanes of a shuffle and the B lanes of a dot product, and it must leave pack alone. The sweep crosses every opcode with both lane sizes, both signedness settings and both replicate settings. Each combination runs on corner words with equal operands, sign-bit lanes and all-ones words, and on pseudo-random words. Every result is judged against an arithmetic lane model that applies replication first and the operation second.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MIN    = 4'd2,
    OP_MAX    = 4'd3,
    OP_EQ     = 4'd4,
    OP_LT     = 4'd5,
    OP_SHUF   = 4'd6,
    OP_PACK   = 4'd7,
    OP_DOT    = 4'd8,
    OP_DOTACC = 4'd9
  } simd_op_e;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic         signed_i,
  output logic [W-1:0] res_o
);
  logic signed [W:0] a_x, b_x;
  logic              a_lt_b;

  // one extra bit makes signed and unsigned order a single compare
  assign a_x    = {signed_i & a_i[W-1], a_i};
  assign b_x    = {signed_i & b_i[W-1], b_i};
  assign a_lt_b = a_x < b_x;

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MIN:  res_o = a_lt_b ? a_i : b_i;
      OP_MAX:  res_o = a_lt_b ? b_i : a_i;
      OP_EQ:   res_o = (a_i == b_i) ? '1 : '0;
      OP_LT:   res_o = a_lt_b ? '1 : '0;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_shuffle.sv
module simd_shuffle #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic [W*N-1:0] a_i,
  input  logic [W*N-1:0] idx_i,
  output logic [W*N-1:0] res_o
);
  localparam int IdxW = (N > 1) ? $clog2(N) : 1;

  for (genvar k = 0; k < N; k++) begin : g_lane
    logic [IdxW-1:0] sel;
    assign sel = idx_i[k*W +: IdxW];
    assign res_o[k*W +: W] = a_i[sel*W +: W];
  end
endmodule

// File: rtl/simd_dot.sv
module simd_dot #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic [W*N-1:0] a_i,
  input  logic [W*N-1:0] b_i,
  input  logic [W*N-1:0] c_i,
  input  logic           signed_i,
  input  logic           acc_i,
  output logic [W*N-1:0] res_o
);
  localparam int DW = W * N;

  logic [DW-1:0] prod [N];

  for (genvar k = 0; k < N; k++) begin : g_mul
    logic [DW-1:0] a_x, b_x;
    assign a_x = {{(DW-W){signed_i & a_i[k*W+W-1]}}, a_i[k*W +: W]};
    assign b_x = {{(DW-W){signed_i & b_i[k*W+W-1]}}, b_i[k*W +: W]};
    assign prod[k] = a_x * b_x;
  end

  always_comb begin
    res_o = acc_i ? c_i : '0;
    for (int k = 0; k < N; k++) res_o = res_o + prod[k];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] op_c_i,
  input  logic [3:0]        op_i,
  input  logic              lane8_i,
  input  logic              signed_i,
  input  logic              scalar_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int NarrowW = DATA_W / 4;
  localparam int WideW   = DATA_W / 2;
  localparam int NarrowN = DATA_W / NarrowW;
  localparam int WideN   = DATA_W / WideW;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] lane_n, lane_w, shuf_n, shuf_w, dot_n, dot_w;
  logic [DATA_W-1:0] res_d;
  logic              dot_acc;

  always_comb begin
    if (!scalar_i)    b_eff = op_b_i;
    else if (lane8_i) b_eff = {NarrowN{op_b_i[NarrowW-1:0]}};
    else              b_eff = {WideN{op_b_i[WideW-1:0]}};
  end

  for (genvar k = 0; k < NarrowN; k++) begin : g_narrow
    simd_lane_op #(.W(NarrowW)) i_lane (
      .a_i(op_a_i[k*NarrowW +: NarrowW]), .b_i(b_eff[k*NarrowW +: NarrowW]),
      .op_i(op_i), .signed_i(signed_i), .res_o(lane_n[k*NarrowW +: NarrowW]));
  end

  for (genvar k = 0; k < WideN; k++) begin : g_wide
    simd_lane_op #(.W(WideW)) i_lane (
      .a_i(op_a_i[k*WideW +: WideW]), .b_i(b_eff[k*WideW +: WideW]),
      .op_i(op_i), .signed_i(signed_i), .res_o(lane_w[k*WideW +: WideW]));
  end

  simd_shuffle #(.W(NarrowW), .N(NarrowN)) i_shuf_n (
    .a_i(op_a_i), .idx_i(b_eff), .res_o(shuf_n));
  simd_shuffle #(.W(WideW), .N(WideN)) i_shuf_w (
    .a_i(op_a_i), .idx_i(b_eff), .res_o(shuf_w));

  assign dot_acc = (op_i == OP_DOTACC);

  simd_dot #(.W(NarrowW), .N(NarrowN)) i_dot_n (
    .a_i(op_a_i), .b_i(b_eff), .c_i(op_c_i), .signed_i(signed_i),
    .acc_i(dot_acc), .res_o(dot_n));
  simd_dot #(.W(WideW), .N(WideN)) i_dot_w (
    .a_i(op_a_i), .b_i(b_eff), .c_i(op_c_i), .signed_i(signed_i),
    .acc_i(dot_acc), .res_o(dot_w));

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_MIN, OP_MAX, OP_EQ, OP_LT:
                        res_d = lane8_i ? lane_n : lane_w;
      OP_SHUF:          res_d = lane8_i ? shuf_n : shuf_w;
      OP_PACK:          res_d = {op_a_i[WideW-1:0], op_b_i[WideW-1:0]};
      OP_DOT, OP_DOTACC: res_d = lane8_i ? dot_n : dot_w;
      default:          res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= res_d;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> result_o == '0);

  // R7
  pack_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_i == OP_PACK) |->
      result_o == {$past(op_a_i[WideW-1:0]), $past(op_b_i[WideW-1:0])});

  // R4
  cmp_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past((op_i == OP_EQ || op_i == OP_LT) && lane8_i) |->
      ((result_o[7:0] == 8'h00 || result_o[7:0] == 8'hff) &&
       (result_o[15:8] == 8'h00 || result_o[15:8] == 8'hff) &&
       (result_o[23:16] == 8'h00 || result_o[23:16] == 8'hff) &&
       (result_o[31:24] == 8'h00 || result_o[31:24] == 8'hff)));

  // R4
  eq_self_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_i == OP_EQ && !scalar_i && op_a_i == op_b_i) |-> result_o == '1);

  // R2
  sub_self_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_i == OP_SUB && !scalar_i && op_a_i == op_b_i) |-> result_o == '0);

  // R6
  shuf_idx0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_i == OP_SHUF && lane8_i && !scalar_i && (op_b_i & 32'h0303_0303) == '0)
      |-> result_o == {NarrowN{$past(op_a_i[NarrowW-1:0])}});

  // R9
  dotacc_zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_i == OP_DOTACC && op_a_i == '0) |-> result_o == $past(op_c_i));

  // R10
  undef_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op_i > OP_DOTACC) |-> result_o == '0);
endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [3:0]  op = '0;
  logic        l8 = 1'b0, sg = 1'b0, sc = 1'b0;
  logic [31:0] res;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1357_9bdf;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_alu i_simd_alu (
    .clk_i(clk), .rst_ni(rst_ni), .op_a_i(a), .op_b_i(b), .op_c_i(c),
    .op_i(op), .lane8_i(l8), .signed_i(sg), .scalar_i(sc), .result_o(res));

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] ma, mb, mc,
                                        input int mop, input bit ml8, msg, msc);
    int w, n;
    longint mask, la, lb, sa, sb, acc, rl, tmp;
    logic [31:0] r;
    if (mop == 7) return {ma[15:0], mb[15:0]};
    w = ml8 ? 8 : 16;
    n = 32 / w;
    mask = (longint'(1) << w) - 1;
    r = '0;
    acc = 0;
    for (int i = 0; i < n; i++) begin
      la = (longint'(ma) >> (i*w)) & mask;
      lb = msc ? (longint'(mb) & mask) : ((longint'(mb) >> (i*w)) & mask);
      sa = (msg && ((la >> (w-1)) & 1) == 1) ? la - (mask + 1) : la;
      sb = (msg && ((lb >> (w-1)) & 1) == 1) ? lb - (mask + 1) : lb;
      case (mop)
        0: rl = (la + lb) & mask;
        1: rl = (la - lb) & mask;
        2: rl = (sa < sb) ? la : lb;
        3: rl = (sa > sb) ? la : lb;
        4: rl = (la == lb) ? mask : 0;
        5: rl = (sa < sb) ? mask : 0;
        6: rl = (longint'(ma) >> ((lb % n) * w)) & mask;
        8, 9: begin acc = acc + sa * sb; rl = 0; end
        default: rl = 0;
      endcase
      tmp = rl << (i*w);
      r = r | tmp[31:0];
    end
    if (mop == 8) r = acc[31:0];
    if (mop == 9) r = acc[31:0] + mc;
    return r;
  endfunction

  function automatic string tag_of(input int top, input bit tsc);
    if (tsc && top != 7 && top < 10) return "R5";
    case (top)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6:       return "R6";
      7:       return "R7";
      8:       return "R8";
      9:       return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d l8=%0b sg=%0b sc=%0b a=%h b=%h c=%h actual=%h expected=%h",
               req, op, l8, sg, sc, a, b, c, res, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ta, tb, tc, input int top,
                       input bit tl8, tsg, tsc);
    @(negedge clk);
    a = ta; b = tb; c = tc; op = top[3:0]; l8 = tl8; sg = tsg; sc = tsc;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(top, tsc), model(ta, tb, tc, top, tl8, tsg, tsc));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb, pc;
    #1 rst_ni = 1'b0;
    a = 32'hdead_beef; b = 32'h1234_5678; op = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'h0);  // reset holds result at zero despite live inputs
    rst_ni = 1'b1;
    // first edge after reset: registered result of the held inputs (R1)
    @(posedge clk);
    @(negedge clk);
    check("R1", model(a, b, c, 0, 1'b0, 1'b0, 1'b0));

    for (int top = 0; top < 16; top++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int p = 0; p < 12; p++) begin
          seed = next_rand(seed); pa = seed;
          seed = next_rand(seed); pb = seed;
          seed = next_rand(seed); pc = seed;
          case (p)
            0: begin pa = 32'h0;         pb = 32'h0;         end
            1: begin pa = 32'hffff_ffff; pb = 32'h0001_0101; end
            2: begin pa = 32'h8080_7f7f; pb = 32'h7f7f_8080; end
            3: begin pa = 32'h1234_5678; pb = 32'h1234_5678; end
            4: begin pa = 32'hffff_ffff; pb = 32'hffff_ffff; end
            5: begin pb = 32'hfcfd_feff; end  // index lanes with high bits set
            default: ;
          endcase
          apply(pa, pb, pc, top, cfg[0], cfg[1], cfg[2]);
        end
      end
    end

    // R8: four-lane unsigned byte dot product, worst case
    apply(32'hffff_ffff, 32'hffff_ffff, 32'h0, 8, 1'b1, 1'b0, 1'b0);
    // R9: accumulate wraps modulo 2^32
    apply(32'hffff_ffff, 32'hffff_ffff, 32'hffff_0000, 9, 1'b1, 1'b0, 1'b0);
    // R2: byte add with no carry between lanes
    apply(32'h80ff_ff01, 32'h80ff_01ff, 32'h0, 0, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule